// File: doc/BRIEF.md
# Debug Exception Context Capture and Commit Unit

This unit keeps the debug-side copy of a hart's exception context: an exception PC copy, a cause copy and a trap-value copy, together with the resume PC, the program-buffer PC, two scratch registers and two save registers. When the hart enters the debug-halted state, the unit captures the faulting context into these copies. If asked to, it also passes that context straight on to the architectural trap registers of the privilege level that was running.

The architectural trap registers do not have to be written at the moment of the trap. The debug copies can be handed over later. On a resume to normal execution, or on the start of program-buffer execution, the unit can push the three copies into the architectural trap registers of the privilege being applied and raise an exception event toward the hart. On every resume or program-buffer start it also produces the PC value the hart loads. While program-buffer code runs it tells the hart whether the PC is frozen.

The architectural register file is outside this unit. Only write enables and data leave it. A single reset, the debug-side reset, clears every register the unit holds. Hart reset is not an input, so a hart reset leaves the whole context intact.

Top module: `dbg_ctx_unit`

## Requirements
- R1: After reset, every owned register reads back 0. trap_we, exc_event, pc_load_vld and pc_freeze are all 0, and the unit is in the normal-run mode.
- R2: One cycle after entry_vld, the exception PC copy (0x7b4), cause copy (0x7b5) and trap-value copy (0x7b6) read back exc_epc, exc_cause and exc_tval as they were in the entry cycle. This holds whatever prev_state is.
- R3: If entry_commit is set on an entry, trap_we in the next cycle has exactly the bit of entry_prv set, and trap_epc/trap_cause/trap_tval carry the entered exception data. The bits are: bit0 for U (entry_prv 0), bit1 for S (1), bit2 for M (3). If entry_commit is clear, trap_we stays 0. An entry never raises exc_event.
- R4: An entry with prev_state 2'b01 (from normal run) loads the resume PC (0x7b1) with next_pc. An entry with prev_state 2'b10 (from program-buffer run) leaves the resume PC unchanged.
- R5: Every entry loads the program-buffer PC (0x7bc) with arch_pc.
- R6: One cycle after resume_vld, pc_load_vld is 1 and pc_load_val equals the resume PC held in the resume cycle.
- R7: If resume_commit is set on a resume, the next cycle has trap_we set for resume_prv, with the three debug copies on the trap data outputs, and exc_event at 1.
- R8: One cycle after pbuf_start, pc_load_vld is 1 and pc_load_val equals the program-buffer PC. If pbuf_commit is set, the copies are committed for pbuf_prv and exc_event is raised, in the same way as in R7.
- R9: A privilege value of 2 selects no target. It suppresses every trap_we bit and exc_event on entry, resume and program-buffer start. pc_load_vld still behaves as in R6 and R8.
- R10: From the cycle after pbuf_start until the cycle after the next entry or resume, pc_freeze equals the inverse of pc_alt_en. At all other times pc_freeze is 0.
- R11: The scratch registers (0x7b2, 0x7b3), save registers (0x7be, 0x7bf), exception copies and program-buffer PC are writable in any mode. The resume PC accepts writes only while the unit is debug-halted. At any other time a write to it is ignored. Addresses not owned by the unit read 0, and writes to them are ignored.
- R12: If an entry and a CSR write hit the same captured register in the same cycle, the captured value wins.
- R13: Priority between strobes in the same cycle is entry, then resume, then program-buffer start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous debug-side reset |
| entry_vld | input | 1 | Hart enters the debug-halted state this cycle |
| prev_state | input | 2 | State before entry: 2'b01 normal run, 2'b10 program-buffer run |
| entry_prv | input | 2 | Privilege in use before entry |
| entry_commit | input | 1 | Also write exception data to architectural trap registers on entry |
| exc_epc | input | XLEN | Exception PC of the entering event |
| exc_cause | input | XLEN | Cause of the entering event |
| exc_tval | input | XLEN | Trap value of the entering event |
| next_pc | input | XLEN | Address of the next instruction at entry |
| arch_pc | input | XLEN | Architectural PC at entry |
| resume_vld | input | 1 | Resume to normal run this cycle |
| resume_prv | input | 2 | Privilege applied on resume |
| resume_commit | input | 1 | Commit debug exception copies on resume |
| pbuf_start | input | 1 | Program-buffer execution starts this cycle |
| pbuf_prv | input | 2 | Privilege applied to program-buffer code |
| pbuf_commit | input | 1 | Commit debug exception copies on program-buffer start |
| pc_alt_en | input | 1 | Allow the PC to change during program-buffer execution |
| csr_we | input | 1 | CSR write strobe |
| csr_addr | input | 12 | CSR address |
| csr_wdata | input | XLEN | CSR write data |
| csr_rdata | output | XLEN | CSR read data for csr_addr (combinational) |
| trap_we | output | 3 | Architectural trap register write enable: bit0 U, bit1 S, bit2 M |
| trap_epc | output | XLEN | Exception PC to write |
| trap_cause | output | XLEN | Cause to write |
| trap_tval | output | XLEN | Trap value to write |
| exc_event | output | 1 | Exception event indication to the hart |
| pc_load_vld | output | 1 | Hart loads its PC from pc_load_val |
| pc_load_val | output | XLEN | PC value to load |
| pc_freeze | output | 1 | PC held during program-buffer execution |

## Verification
On every cycle, the assertions check that the trap write enable is one-hot or idle, and that any enable or exception event traces back to a strobe with its commit bit one cycle earlier. They also check that privilege 2 blocks the commit, that the program-buffer PC follows arch_pc after every entry, that a resume loads the held resume PC, and that the freeze flag follows pc_alt_en after a program-buffer start. Other behaviour can only be shown by the bench's scenarios against its reference model. This covers the choice between the resume-PC update and no update, depending on the previous state. It also covers the refusal of resume-PC writes outside the halted mode, the priority of capture over a colliding CSR write, the ordering of simultaneous strobes, and the readback of unowned addresses as zero.

// File: rtl/dbg_ctx_pkg.sv
// Shared constants and helpers for the debug exception context unit.
// Assumes a 12-bit CSR address space; privilege coded 0=U, 1=S, 3=M.
package dbg_ctx_pkg;

    localparam int CSR_AW = 12;

    localparam logic [CSR_AW-1:0] ADDR_RPC   = 12'h7b1;
    localparam logic [CSR_AW-1:0] ADDR_SCR0  = 12'h7b2;
    localparam logic [CSR_AW-1:0] ADDR_SCR1  = 12'h7b3;
    localparam logic [CSR_AW-1:0] ADDR_XPC   = 12'h7b4;
    localparam logic [CSR_AW-1:0] ADDR_XCAU  = 12'h7b5;
    localparam logic [CSR_AW-1:0] ADDR_XVAL  = 12'h7b6;
    localparam logic [CSR_AW-1:0] ADDR_PBPC  = 12'h7bc;
    localparam logic [CSR_AW-1:0] ADDR_SAV0  = 12'h7be;
    localparam logic [CSR_AW-1:0] ADDR_SAV1  = 12'h7bf;

    localparam int NUM_PLAIN = 4;

    // Encoding of the previous-state input
    localparam logic [1:0] PREV_RUN  = 2'b01;
    localparam logic [1:0] PREV_PBUF = 2'b10;

    typedef enum logic [1:0] {
        MODE_RUN   = 2'd0,
        MODE_HALT  = 2'd1,
        MODE_PBUF  = 2'd2
    } dbg_mode_e;

    // Address of plain read/write register number idx
    function automatic logic [CSR_AW-1:0] plain_addr(input int idx);
        case (idx)
            0:       plain_addr = ADDR_SCR0;
            1:       plain_addr = ADDR_SCR1;
            2:       plain_addr = ADDR_SAV0;
            default: plain_addr = ADDR_SAV1;
        endcase
    endfunction

    // Privilege to trap-register bank select; value 2 selects nothing
    function automatic logic [2:0] prv_bank(input logic [1:0] prv);
        case (prv)
            2'd0:    prv_bank = 3'b001;
            2'd1:    prv_bank = 3'b010;
            2'd3:    prv_bank = 3'b100;
            default: prv_bank = 3'b000;
        endcase
    endfunction

endpackage

// File: rtl/dbg_ctx_store.sv
// Holds the debug context registers and serves CSR reads and writes.
// Captures exception data and PCs on entry; a capture overrides a
// CSR write to the same register in that cycle. Resume-PC writes are
// taken only when wr_rpc_ok is high.
module dbg_ctx_store
    import dbg_ctx_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic              cap_rpc_en,
    input  logic [XLEN-1:0]   exc_epc,
    input  logic [XLEN-1:0]   exc_cause,
    input  logic [XLEN-1:0]   exc_tval,
    input  logic [XLEN-1:0]   next_pc,
    input  logic [XLEN-1:0]   arch_pc,
    input  logic              wr_rpc_ok,
    input  logic              csr_we,
    input  logic [CSR_AW-1:0] csr_addr,
    input  logic [XLEN-1:0]   csr_wdata,
    output logic [XLEN-1:0]   csr_rdata,
    output logic [XLEN-1:0]   rpc_q,
    output logic [XLEN-1:0]   pbpc_q,
    output logic [XLEN-1:0]   xpc_q,
    output logic [XLEN-1:0]   xcau_q,
    output logic [XLEN-1:0]   xval_q
);

    logic [XLEN-1:0] plain_q [NUM_PLAIN];

    // Exception copies: capture on entry, else CSR write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xpc_q  <= '0;
            xcau_q <= '0;
            xval_q <= '0;
        end else if (cap_en) begin
            xpc_q  <= exc_epc;
            xcau_q <= exc_cause;
            xval_q <= exc_tval;
        end else if (csr_we) begin
            if (csr_addr == ADDR_XPC)  xpc_q  <= csr_wdata;
            if (csr_addr == ADDR_XCAU) xcau_q <= csr_wdata;
            if (csr_addr == ADDR_XVAL) xval_q <= csr_wdata;
        end
    end

    // Resume PC: next_pc on entry from normal run, else gated CSR write
    always_ff @(posedge clk) begin
        if (!rst_n)
            rpc_q <= '0;
        else if (cap_rpc_en)
            rpc_q <= next_pc;
        else if (!cap_en && csr_we && wr_rpc_ok && csr_addr == ADDR_RPC)
            rpc_q <= csr_wdata;
    end

    // Program-buffer PC: architectural PC on any entry, else CSR write
    always_ff @(posedge clk) begin
        if (!rst_n)
            pbpc_q <= '0;
        else if (cap_en)
            pbpc_q <= arch_pc;
        else if (csr_we && csr_addr == ADDR_PBPC)
            pbpc_q <= csr_wdata;
    end

    // Scratch and save registers: plain read/write storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_PLAIN; i++) plain_q[i] <= '0;
        end else if (csr_we) begin
            for (int i = 0; i < NUM_PLAIN; i++)
                if (csr_addr == plain_addr(i)) plain_q[i] <= csr_wdata;
        end
    end

    // Read multiplexer; unowned addresses return zero
    always_comb begin
        csr_rdata = '0;
        case (csr_addr)
            ADDR_RPC:  csr_rdata = rpc_q;
            ADDR_XPC:  csr_rdata = xpc_q;
            ADDR_XCAU: csr_rdata = xcau_q;
            ADDR_XVAL: csr_rdata = xval_q;
            ADDR_PBPC: csr_rdata = pbpc_q;
            default: begin
                for (int i = 0; i < NUM_PLAIN; i++)
                    if (csr_addr == plain_addr(i)) csr_rdata = plain_q[i];
            end
        endcase
    end

endmodule

// File: rtl/dbg_ctx_xfer.sv
// Selects and registers the transfer toward the hart: the trap-register
// write, the exception event and the PC load. Priority: entry, resume,
// program-buffer start. All outputs appear one cycle after the strobe.
module dbg_ctx_xfer
    import dbg_ctx_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            entry_go,
    input  logic            entry_commit,
    input  logic [1:0]      entry_prv,
    input  logic [XLEN-1:0] exc_epc,
    input  logic [XLEN-1:0] exc_cause,
    input  logic [XLEN-1:0] exc_tval,
    input  logic            resume_go,
    input  logic            resume_commit,
    input  logic [1:0]      resume_prv,
    input  logic            pbuf_go,
    input  logic            pbuf_commit,
    input  logic [1:0]      pbuf_prv,
    input  logic [XLEN-1:0] rpc_q,
    input  logic [XLEN-1:0] pbpc_q,
    input  logic [XLEN-1:0] xpc_q,
    input  logic [XLEN-1:0] xcau_q,
    input  logic [XLEN-1:0] xval_q,
    output logic [2:0]      trap_we,
    output logic [XLEN-1:0] trap_epc,
    output logic [XLEN-1:0] trap_cause,
    output logic [XLEN-1:0] trap_tval,
    output logic            exc_event,
    output logic            pc_load_vld,
    output logic [XLEN-1:0] pc_load_val
);

    logic [XLEN-1:0] src_epc, src_cause, src_tval, ld_val;
    logic [1:0]      sel_prv;
    logic            do_commit, raise_evt, do_load;
    logic [2:0]      we_nxt;

    // Choose the source of the transfer by strobe priority
    always_comb begin
        src_epc   = xpc_q;
        src_cause = xcau_q;
        src_tval  = xval_q;
        sel_prv   = 2'd2;
        do_commit = 1'b0;
        raise_evt = 1'b0;
        do_load   = 1'b0;
        ld_val    = rpc_q;
        if (entry_go) begin
            src_epc   = exc_epc;
            src_cause = exc_cause;
            src_tval  = exc_tval;
            sel_prv   = entry_prv;
            do_commit = entry_commit;
        end else if (resume_go) begin
            sel_prv   = resume_prv;
            do_commit = resume_commit;
            raise_evt = resume_commit;
            do_load   = 1'b1;
        end else if (pbuf_go) begin
            sel_prv   = pbuf_prv;
            do_commit = pbuf_commit;
            raise_evt = pbuf_commit;
            do_load   = 1'b1;
            ld_val    = pbpc_q;
        end
        we_nxt = do_commit ? prv_bank(sel_prv) : 3'b000;
    end

    // Register the transfer outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trap_we     <= '0;
            trap_epc    <= '0;
            trap_cause  <= '0;
            trap_tval   <= '0;
            exc_event   <= 1'b0;
            pc_load_vld <= 1'b0;
            pc_load_val <= '0;
        end else begin
            trap_we     <= we_nxt;
            trap_epc    <= src_epc;
            trap_cause  <= src_cause;
            trap_tval   <= src_tval;
            exc_event   <= raise_evt && (we_nxt != 3'b000);
            pc_load_vld <= do_load;
            pc_load_val <= ld_val;
        end
    end

endmodule

// File: rtl/dbg_ctx_unit.sv
// Top of the debug exception context unit. Tracks the debug mode
// (run, halted, program-buffer run) from the strobes, gates resume-PC
// writes to the halted mode and drives the PC freeze flag.
// Assumes strobes are single-cycle and legal for the current state.
module dbg_ctx_unit
    import dbg_ctx_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              entry_vld,
    input  logic [1:0]        prev_state,
    input  logic [1:0]        entry_prv,
    input  logic              entry_commit,
    input  logic [XLEN-1:0]   exc_epc,
    input  logic [XLEN-1:0]   exc_cause,
    input  logic [XLEN-1:0]   exc_tval,
    input  logic [XLEN-1:0]   next_pc,
    input  logic [XLEN-1:0]   arch_pc,
    input  logic              resume_vld,
    input  logic [1:0]        resume_prv,
    input  logic              resume_commit,
    input  logic              pbuf_start,
    input  logic [1:0]        pbuf_prv,
    input  logic              pbuf_commit,
    input  logic              pc_alt_en,
    input  logic              csr_we,
    input  logic [CSR_AW-1:0] csr_addr,
    input  logic [XLEN-1:0]   csr_wdata,
    output logic [XLEN-1:0]   csr_rdata,
    output logic [2:0]        trap_we,
    output logic [XLEN-1:0]   trap_epc,
    output logic [XLEN-1:0]   trap_cause,
    output logic [XLEN-1:0]   trap_tval,
    output logic              exc_event,
    output logic              pc_load_vld,
    output logic [XLEN-1:0]   pc_load_val,
    output logic              pc_freeze
);

    dbg_mode_e       mode_q;
    logic [XLEN-1:0] rpc_q, pbpc_q, xpc_q, xcau_q, xval_q;
    logic            resume_go, pbuf_go;

    assign resume_go = resume_vld && !entry_vld;
    assign pbuf_go   = pbuf_start && !entry_vld && !resume_vld;

    // Debug mode tracking by strobe priority
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_q <= MODE_RUN;
        else if (entry_vld)
            mode_q <= MODE_HALT;
        else if (resume_go)
            mode_q <= MODE_RUN;
        else if (pbuf_go)
            mode_q <= MODE_PBUF;
    end

    assign pc_freeze = (mode_q == MODE_PBUF) && !pc_alt_en;

    dbg_ctx_store #(.XLEN(XLEN)) store_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cap_en     (entry_vld),
        .cap_rpc_en (entry_vld && prev_state == PREV_RUN),
        .exc_epc    (exc_epc),
        .exc_cause  (exc_cause),
        .exc_tval   (exc_tval),
        .next_pc    (next_pc),
        .arch_pc    (arch_pc),
        .wr_rpc_ok  (mode_q == MODE_HALT),
        .csr_we     (csr_we),
        .csr_addr   (csr_addr),
        .csr_wdata  (csr_wdata),
        .csr_rdata  (csr_rdata),
        .rpc_q      (rpc_q),
        .pbpc_q     (pbpc_q),
        .xpc_q      (xpc_q),
        .xcau_q     (xcau_q),
        .xval_q     (xval_q)
    );

    dbg_ctx_xfer #(.XLEN(XLEN)) xfer_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .entry_go      (entry_vld),
        .entry_commit  (entry_commit),
        .entry_prv     (entry_prv),
        .exc_epc       (exc_epc),
        .exc_cause     (exc_cause),
        .exc_tval      (exc_tval),
        .resume_go     (resume_go),
        .resume_commit (resume_commit),
        .resume_prv    (resume_prv),
        .pbuf_go       (pbuf_go),
        .pbuf_commit   (pbuf_commit),
        .pbuf_prv      (pbuf_prv),
        .rpc_q         (rpc_q),
        .pbpc_q        (pbpc_q),
        .xpc_q         (xpc_q),
        .xcau_q        (xcau_q),
        .xval_q        (xval_q),
        .trap_we       (trap_we),
        .trap_epc      (trap_epc),
        .trap_cause    (trap_cause),
        .trap_tval     (trap_tval),
        .exc_event     (exc_event),
        .pc_load_vld   (pc_load_vld),
        .pc_load_val   (pc_load_val)
    );

endmodule

// File: rtl/dbg_ctx_unit_chk.sv
// Assertion checker for dbg_ctx_unit, attached through bind.
// Relates strobes to the registered transfer outputs and stored PCs.
module dbg_ctx_unit_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            entry_vld,
    input logic [1:0]      entry_prv,
    input logic            entry_commit,
    input logic [XLEN-1:0] arch_pc,
    input logic            resume_vld,
    input logic            resume_commit,
    input logic            pbuf_start,
    input logic            pbuf_commit,
    input logic            pc_alt_en,
    input logic [2:0]      trap_we,
    input logic            exc_event,
    input logic            pc_load_vld,
    input logic [XLEN-1:0] pc_load_val,
    input logic            pc_freeze,
    input logic [XLEN-1:0] rpc_q,
    input logic [XLEN-1:0] pbpc_q
);

    assert_we_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(trap_we));

    assert_we_has_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_we != 3'b000) |-> $past((entry_vld && entry_commit) ||
                                      (resume_vld && resume_commit) ||
                                      (pbuf_start && pbuf_commit)));

    assert_event_has_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
        exc_event |-> ($past(resume_vld || pbuf_start) && trap_we != 3'b000));

    assert_prv2_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (entry_vld && entry_commit && entry_prv == 2'd2) |=> (trap_we == 3'b000 && !exc_event));

    assert_pbpc_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
        entry_vld |=> (pbpc_q == $past(arch_pc)));

    assert_resume_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (resume_vld && !entry_vld) |=> (pc_load_vld && pc_load_val == $past(rpc_q)));

    assert_freeze_follow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pbuf_start && !entry_vld && !resume_vld) |=> (pc_freeze == !pc_alt_en));

endmodule

bind dbg_ctx_unit dbg_ctx_unit_chk #(.XLEN(XLEN)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .entry_vld     (entry_vld),
    .entry_prv     (entry_prv),
    .entry_commit  (entry_commit),
    .arch_pc       (arch_pc),
    .resume_vld    (resume_vld),
    .resume_commit (resume_commit),
    .pbuf_start    (pbuf_start),
    .pbuf_commit   (pbuf_commit),
    .pc_alt_en     (pc_alt_en),
    .trap_we       (trap_we),
    .exc_event     (exc_event),
    .pc_load_vld   (pc_load_vld),
    .pc_load_val   (pc_load_val),
    .pc_freeze     (pc_freeze),
    .rpc_q         (rpc_q),
    .pbpc_q        (pbpc_q)
);

// File: tb/dbg_ctx_unit_tb_top.sv
// Bench for dbg_ctx_unit: a behavioural reference model stepped each
// clock and compared with every output at the falling edge.
module dbg_ctx_unit_tb_top;

    localparam int XLEN = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            entry_vld = 0, entry_commit = 0;
    logic [1:0]      prev_state = 0, entry_prv = 0;
    logic [XLEN-1:0] exc_epc = 0, exc_cause = 0, exc_tval = 0, next_pc = 0, arch_pc = 0;
    logic            resume_vld = 0, resume_commit = 0;
    logic [1:0]      resume_prv = 0, pbuf_prv = 0;
    logic            pbuf_start = 0, pbuf_commit = 0, pc_alt_en = 0;
    logic            csr_we = 0;
    logic [11:0]     csr_addr = 0;
    logic [XLEN-1:0] csr_wdata = 0;
    logic [XLEN-1:0] csr_rdata, trap_epc, trap_cause, trap_tval, pc_load_val;
    logic [2:0]      trap_we;
    logic            exc_event, pc_load_vld, pc_freeze;

    always #10 clk = ~clk;

    dbg_ctx_unit #(.XLEN(XLEN)) dut_i (.*);

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";

    // Reference model state
    logic [XLEN-1:0] m_xpc, m_xcau, m_xval, m_rpc, m_pbpc;
    logic [XLEN-1:0] m_plain [int];
    int              m_mode;  // 0 run, 1 halted, 2 program buffer
    logic [2:0]      m_we;
    logic [XLEN-1:0] m_tepc, m_tcau, m_tval;
    logic            m_ev, m_ld;
    logic [XLEN-1:0] m_ldv;

    function automatic logic [2:0] bank(input logic [1:0] p);
        if (p == 2'd0) return 3'b001;
        if (p == 2'd1) return 3'b010;
        if (p == 2'd3) return 3'b100;
        return 3'b000;
    endfunction

    function automatic logic [XLEN-1:0] m_read(input logic [11:0] a);
        case (a)
            12'h7b1: return m_rpc;
            12'h7b4: return m_xpc;
            12'h7b5: return m_xcau;
            12'h7b6: return m_xval;
            12'h7bc: return m_pbpc;
            12'h7b2, 12'h7b3, 12'h7be, 12'h7bf: return m_plain[int'(a)];
            default: return '0;
        endcase
    endfunction

    task automatic m_reset();
        m_xpc = 0; m_xcau = 0; m_xval = 0; m_rpc = 0; m_pbpc = 0;
        m_plain[12'h7b2] = 0; m_plain[12'h7b3] = 0;
        m_plain[12'h7be] = 0; m_plain[12'h7bf] = 0;
        m_mode = 0; m_we = 0; m_tepc = 0; m_tcau = 0; m_tval = 0;
        m_ev = 0; m_ld = 0; m_ldv = 0;
    endtask

    // Advance the model by one clock using the current inputs
    task automatic m_step();
        logic [XLEN-1:0] o_xpc, o_xcau, o_xval, o_rpc, o_pbpc;
        int o_mode;
        o_xpc = m_xpc; o_xcau = m_xcau; o_xval = m_xval;
        o_rpc = m_rpc; o_pbpc = m_pbpc; o_mode = m_mode;
        m_we = 0; m_ev = 0; m_ld = 0;
        if (csr_we) begin
            case (csr_addr)
                12'h7b1: if (o_mode == 1) m_rpc = csr_wdata;
                12'h7b4: m_xpc = csr_wdata;
                12'h7b5: m_xcau = csr_wdata;
                12'h7b6: m_xval = csr_wdata;
                12'h7bc: m_pbpc = csr_wdata;
                12'h7b2, 12'h7b3, 12'h7be, 12'h7bf: m_plain[int'(csr_addr)] = csr_wdata;
                default: ;
            endcase
        end
        if (entry_vld) begin
            m_xpc = exc_epc; m_xcau = exc_cause; m_xval = exc_tval;
            m_pbpc = arch_pc;
            if (prev_state == 2'b01) m_rpc = next_pc;
            else m_rpc = (csr_we && csr_addr == 12'h7b1 && o_mode == 1) ? o_rpc : m_rpc;
            m_tepc = exc_epc; m_tcau = exc_cause; m_tval = exc_tval;
            m_we = entry_commit ? bank(entry_prv) : 3'b000;
            m_mode = 1;
        end else if (resume_vld) begin
            m_ld = 1; m_ldv = o_rpc;
            m_tepc = o_xpc; m_tcau = o_xcau; m_tval = o_xval;
            m_we = resume_commit ? bank(resume_prv) : 3'b000;
            m_ev = resume_commit && m_we != 0;
            m_mode = 0;
        end else if (pbuf_start) begin
            m_ld = 1; m_ldv = o_pbpc;
            m_tepc = o_xpc; m_tcau = o_xcau; m_tval = o_xval;
            m_we = pbuf_commit ? bank(pbuf_prv) : 3'b000;
            m_ev = pbuf_commit && m_we != 0;
            m_mode = 2;
        end
    endtask

    task automatic chk(input string what, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
        end
    endtask

    task automatic compare();
        chk("trap_we", {29'd0, trap_we}, {29'd0, m_we});
        if (m_we != 0) begin
            chk("trap_epc", trap_epc, m_tepc);
            chk("trap_cause", trap_cause, m_tcau);
            chk("trap_tval", trap_tval, m_tval);
        end
        chk("exc_event", {31'd0, exc_event}, {31'd0, m_ev});
        chk("pc_load_vld", {31'd0, pc_load_vld}, {31'd0, m_ld});
        if (m_ld) chk("pc_load_val", pc_load_val, m_ldv);
        chk("pc_freeze", {31'd0, pc_freeze}, {31'd0, (m_mode == 2) && !pc_alt_en});
        chk("csr_rdata", csr_rdata, m_read(csr_addr));
    endtask

    // One clock: model advance, edge, clear strobes, compare
    task automatic tick();
        if (rst_n) m_step();
        @(posedge clk);
        @(negedge clk);
        entry_vld = 0; resume_vld = 0; pbuf_start = 0; csr_we = 0;
        compare();
    endtask

    task automatic csr_write(input logic [11:0] a, input logic [XLEN-1:0] d);
        csr_we = 1; csr_addr = a; csr_wdata = d;
        tick();
    endtask

    task automatic csr_look(input logic [11:0] a);
        csr_addr = a;
        #1;
        compare();
    endtask

    task automatic enter(input logic [1:0] ps, input logic [1:0] p, input logic c,
                         input logic [XLEN-1:0] base);
        entry_vld = 1; prev_state = ps; entry_prv = p; entry_commit = c;
        exc_epc = base + 32'h10; exc_cause = base + 32'h2; exc_tval = base + 32'h33;
        next_pc = base + 32'h14; arch_pc = base + 32'h18;
        tick();
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        m_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R1: reset state on every owned address
        cur_req = "R1";
        compare();
        foreach (m_plain[k]) csr_look(12'(k));
        csr_look(12'h7b1); csr_look(12'h7b4); csr_look(12'h7bc);

        // R11: plain registers and copies writable, unowned ignored
        cur_req = "R11";
        csr_write(12'h7b2, 32'hA5A5_0001); csr_write(12'h7b3, 32'hA5A5_0002);
        csr_write(12'h7be, 32'hA5A5_0003); csr_write(12'h7bf, 32'hA5A5_0004);
        csr_write(12'h7b5, 32'h0000_00C5); csr_write(12'h7bc, 32'h0000_0800);
        csr_write(12'h7b7, 32'hFFFF_FFFF); csr_look(12'h7b7);
        csr_look(12'h7b2); csr_look(12'h7bf); csr_look(12'h7b5); csr_look(12'h7bc);
        // R11: resume-PC write outside halted mode is ignored
        csr_write(12'h7b1, 32'hDEAD_0000); csr_look(12'h7b1);

        // R2 R4 R5: entry from normal run, no commit (R3 no write)
        cur_req = "R2";
        csr_addr = 12'h7b4;
        enter(2'b01, 2'd3, 1'b0, 32'h1000);
        csr_look(12'h7b5); csr_look(12'h7b6);
        cur_req = "R4"; csr_look(12'h7b1);
        cur_req = "R5"; csr_look(12'h7bc);

        // R11: resume-PC write accepted while halted
        cur_req = "R11";
        csr_write(12'h7b1, 32'h0000_4000); csr_look(12'h7b1);

        // R6 R7: resume with commit into S bank
        cur_req = "R7";
        resume_vld = 1; resume_prv = 2'd1; resume_commit = 1; tick();
        cur_req = "R6";
        resume_vld = 1; resume_prv = 2'd0; resume_commit = 0; tick();

        // R3: entry with commit into U bank
        cur_req = "R3";
        enter(2'b01, 2'd0, 1'b1, 32'h2000);
        tick();

        // R8 R10: program-buffer start with commit, PC frozen
        cur_req = "R8";
        pc_alt_en = 0;
        pbuf_start = 1; pbuf_prv = 2'd3; pbuf_commit = 1; tick();
        cur_req = "R10";
        tick();
        pc_alt_en = 1; #1; compare();
        pc_alt_en = 0; #1; compare();

        // R4: entry from program-buffer run leaves resume PC alone
        cur_req = "R4";
        csr_addr = 12'h7b1;
        enter(2'b10, 2'd3, 1'b1, 32'h3000);
        cur_req = "R10"; tick();

        // R9: privilege 2 suppresses commit on resume and entry
        cur_req = "R9";
        resume_vld = 1; resume_prv = 2'd2; resume_commit = 1; tick();
        enter(2'b01, 2'd2, 1'b1, 32'h4000);
        pbuf_start = 1; pbuf_prv = 2'd2; pbuf_commit = 1; tick();

        // R12: capture beats CSR write to the same copy
        cur_req = "R12";
        csr_we = 1; csr_addr = 12'h7b4; csr_wdata = 32'h1234_5678;
        enter(2'b10, 2'd1, 1'b0, 32'h5000);
        csr_look(12'h7b4);

        // R13: entry wins over a simultaneous resume
        cur_req = "R13";
        resume_vld = 1; resume_prv = 2'd3; resume_commit = 1;
        enter(2'b10, 2'd1, 1'b1, 32'h6000);
        // R13: resume wins over a simultaneous program-buffer start
        resume_vld = 1; resume_prv = 2'd0; resume_commit = 1;
        pbuf_start = 1; pbuf_prv = 2'd3; pbuf_commit = 0;
        tick();
        tick();

        finish_run();
    end

endmodule